// File: doc/BRIEF.md
# Key-Protected System Configuration Registers

This block holds a chip's system configuration state behind a small 32-bit register bus. It has a device-configuration word of port-mux selects and feature enables, a clock-divider word, a read-only information word that carries the silicon revision, and a key register. The two configuration words are guarded. Software must write the key value to the key register, and the very next bus write is the one allowed to change a guarded word. Any write consumes the key, so each guarded update needs its own key write.

The register bits leave the block as plain outputs. Pin-mux and clock logic elsewhere use them directly. The top bit of the device-configuration word is a software-reset request. When software sets that bit and later clears it, with each write unlocked, the block emits a one-cycle reset-request pulse for the reset controller. Software typically reads the device-configuration word, changes a few bits, writes the key and then writes the whole word back.

Top module: `syscfg_regs`

## Requirements
- R1: A write of 0x000000AA to the key register (byte offset 0xC) arms the unlock. The key register reads 1 in bit 0 while armed and 0 otherwise, with all other bits 0. A second key write while armed keeps the unlock armed.
- R2: Any bus write other than a key write of 0x000000AA disarms the unlock. This includes a key write of any other value and writes to unguarded registers. Reads never change the armed state.
- R3: A write to the device-configuration register (offset 0x4) or the clock-divider register (offset 0x8) changes it only when the unlock is armed. Otherwise the write is ignored.
- R4: After reset, the unlock is disarmed, the reset-request output is low, the clock divider is 0 and device configuration is 0x000000F0. Bits 7:4 are the four port-mux selects, and 1 selects general-purpose I/O.
- R5: All 32 bits of the device-configuration register are writable, and it reads back exactly as written, so software can do read-modify-write. The devcfg_o output always equals the readable value.
- R6: Only the low 16 bits of the clock-divider register are stored. Bits 31:16 read 0, and clkdiv_o equals the readable value.
- R7: The information register (offset 0x0) reads the 4-bit revision 0x5 in bits 31:28 and 0 elsewhere. Writes to it have no effect on its value.
- R8: The reset request (bit 31 of device configuration) pulses soft_rst_o high for exactly one cycle. The pulse occurs in the cycle after an unlocked write that takes bit 31 from 1 to 0. Setting the bit, or rewriting it as 0 when it is already 0, gives no pulse.
- R9: Accesses with a non-zero byte offset within the word (address bits 1:0) select no register. Such reads return 0, and such writes change no register but still disarm the unlock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| devcfg_o | output | 32 | Device-configuration bits |
| clkdiv_o | output | 32 | Clock-divider value, zero-extended |
| soft_rst_o | output | 1 | One-cycle software reset request |

## Verification
The bench targets the lifetime of the key. It checks a read between key and write, a wrong key value, a key consumed by a write to the read-only word, and a misaligned write. A design that kept the unlock across writes, or cleared it on reads, would let a second guarded write through or refuse a valid one. The bench also checks the reset pulse. It sets bit 31 unlocked, tries a locked clear that must produce neither a change nor a pulse, and then does a keyed clear. A design that pulsed on the wrong edge, ignored the lock, or held the pulse for more than one cycle shows a wrong soft_rst_o sample. Read-back of all 32 device-configuration bits and the truncated divider catch lost or leaking bits.

// File: rtl/syscfg_pkg.sv
package syscfg_pkg;

   typedef enum logic [1:0] {
      SEL_INFO   = 2'd0,
      SEL_DEVCFG = 2'd1,
      SEL_CLKDIV = 2'd2,
      SEL_KEY    = 2'd3
   } syscfg_sel_e;

   typedef struct packed {
      logic        hit;
      syscfg_sel_e sel;
   } syscfg_dec_t;

endpackage

// File: rtl/syscfg_decode.sv
module syscfg_decode #(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0]        addr,
   output syscfg_pkg::syscfg_dec_t  dec
);
   import syscfg_pkg::*;

   logic upper_zero;

   generate
      if (ADDR_W < 4) begin : g_bad_addr
         $error("syscfg_decode: ADDR_W must be at least 4");
      end
      if (ADDR_W > 4) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:4] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      dec.hit = upper_zero && (addr[1:0] == 2'b00);
      dec.sel = syscfg_sel_e'(addr[3:2]);
   end

endmodule

// File: rtl/syscfg_key.sv
module syscfg_key #(
   parameter int              DATA_W  = 32,
   parameter logic [DATA_W-1:0] KEY_VAL = 32'h0000_00AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_any,
   input  logic              wr_key,
   input  logic [DATA_W-1:0] wdata,
   output logic              armed_q
);

   logic key_match;
   assign key_match = wr_key && (wdata == KEY_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
      end else if (wr_any) begin
         armed_q <= key_match;
      end
   end

   // R2
   key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_any && !wr_key) |=> !armed_q);

   // R2
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_any |=> $stable(armed_q));

endmodule

// File: rtl/syscfg_preg.sv
module syscfg_preg #(
   parameter int         W   = 32,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST;
      end else if (wr_en) begin
         q <= wdata;
      end
   end

   // R3
   preg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

endmodule

// File: rtl/syscfg_swrst.sv
module syscfg_swrst (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic old_bit,
   input  logic new_bit,
   output logic pulse_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= fire && old_bit && !new_bit;
      end
   end

   // R8
   pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q |=> !pulse_q);

endmodule

// File: rtl/syscfg_regs.sv
module syscfg_regs #(
   parameter int                DATA_W     = 32,
   parameter int                ADDR_W     = 4,
   parameter int                CLKDIV_W   = 16,
   parameter int                REV_W      = 4,
   parameter int                REV_LSB    = 28,
   parameter logic [REV_W-1:0]  REV_VAL    = 4'h5,
   parameter int                SWRST_BIT  = 31,
   parameter logic [DATA_W-1:0] DEVCFG_RST = 32'h0000_00F0,
   parameter logic [DATA_W-1:0] KEY_VAL    = 32'h0000_00AA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [DATA_W-1:0] devcfg_o,
   output logic [DATA_W-1:0] clkdiv_o,
   output logic              soft_rst_o
);
   import syscfg_pkg::*;

   localparam logic [DATA_W-1:0] INFO_WORD =
      DATA_W'(REV_VAL) << REV_LSB;

   generate
      if (REV_LSB + REV_W > DATA_W) begin : g_bad_rev
         $error("syscfg_regs: revision field exceeds data width");
      end
      if (CLKDIV_W < 1 || CLKDIV_W > DATA_W) begin : g_bad_div
         $error("syscfg_regs: CLKDIV_W out of range");
      end
      if (SWRST_BIT >= DATA_W) begin : g_bad_rst
         $error("syscfg_regs: SWRST_BIT out of range");
      end
   endgenerate

   syscfg_dec_t dec;
   logic        wr_any;
   logic        wr_key;
   logic        wr_devcfg;
   logic        wr_clkdiv;
   logic        armed;
   logic [CLKDIV_W-1:0] div_q;

   syscfg_decode #(.ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .dec  (dec)
   );

   assign wr_any    = bus_sel && bus_wr;
   assign wr_key    = wr_any && dec.hit && (dec.sel == SEL_KEY);
   assign wr_devcfg = wr_any && dec.hit && (dec.sel == SEL_DEVCFG);
   assign wr_clkdiv = wr_any && dec.hit && (dec.sel == SEL_CLKDIV);

   syscfg_key #(.DATA_W(DATA_W), .KEY_VAL(KEY_VAL)) u_key (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_any  (wr_any),
      .wr_key  (wr_key),
      .wdata   (bus_wdata),
      .armed_q (armed)
   );

   syscfg_preg #(.W(DATA_W), .RST(DEVCFG_RST)) u_devcfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_devcfg && armed),
      .wdata (bus_wdata),
      .q     (devcfg_o)
   );

   syscfg_preg #(.W(CLKDIV_W), .RST('0)) u_clkdiv (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_clkdiv && armed),
      .wdata (bus_wdata[CLKDIV_W-1:0]),
      .q     (div_q)
   );

   generate
      if (CLKDIV_W < DATA_W) begin : g_div_pad
         assign clkdiv_o = {{(DATA_W-CLKDIV_W){1'b0}}, div_q};
      end else begin : g_div_full
         assign clkdiv_o = div_q;
      end
   endgenerate

   syscfg_swrst u_swrst (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (wr_devcfg && armed),
      .old_bit (devcfg_o[SWRST_BIT]),
      .new_bit (bus_wdata[SWRST_BIT]),
      .pulse_q (soft_rst_o)
   );

   always_comb begin
      bus_rdata = '0;
      if (dec.hit) begin
         case (dec.sel)
            SEL_INFO:   bus_rdata = INFO_WORD;
            SEL_DEVCFG: bus_rdata = devcfg_o;
            SEL_CLKDIV: bus_rdata = clkdiv_o;
            SEL_KEY:    bus_rdata = {{(DATA_W-1){1'b0}}, armed};
            default:    bus_rdata = '0;
         endcase
      end
   end

   // R3
   locked_devcfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_devcfg && !armed) |=> $stable(devcfg_o));

   // R3
   locked_clkdiv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clkdiv && !armed) |=> $stable(clkdiv_o));

   // R8
   pulse_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_o |-> ($past(devcfg_o[SWRST_BIT]) && !devcfg_o[SWRST_BIT]));

   // R1
   key_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && dec.hit && dec.sel == SEL_KEY) |-> (bus_rdata[DATA_W-1:1] == '0));

endmodule

// File: tb/test_syscfg_regs.sv
module test_syscfg_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] devcfg_o;
   logic [31:0] clkdiv_o;
   logic        soft_rst_o;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #10 clk = ~clk;

   syscfg_regs i_syscfg_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .devcfg_o   (devcfg_o),
      .clkdiv_o   (clkdiv_o),
      .soft_rst_o (soft_rst_o)
   );

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read data and compares
   always @(negedge clk) begin
      if (bus_sel && !bus_wr) begin
         if (exp_q.size() == 0) begin
            check("scoreboard-empty", 32'h1, 32'h0);
         end else begin
            automatic logic [31:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(t, bus_rdata, e);
         end
      end
   end

   task automatic rd(logic [3:0] a, logic [31:0] e, string t);
      exp_q.push_back(e);
      tag_q.push_back(t);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(posedge clk); #1;
      bus_sel = 1'b0;
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic pulse_chk(logic first, string t);
      @(negedge clk);
      check(t, {31'b0, soft_rst_o}, {31'b0, first});
      @(posedge clk); #1;
      @(negedge clk);
      check(t, {31'b0, soft_rst_o}, 32'h0);
      @(posedge clk); #1;
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_checks - n_fails, n_checks);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R4 reset state
      @(negedge clk);
      check("R4 pulse low", {31'b0, soft_rst_o}, 32'h0);
      check("R4 devcfg_o", devcfg_o, 32'h0000_00F0);
      @(posedge clk); #1;
      rd(4'h4, 32'h0000_00F0, "R4 devcfg reset");
      rd(4'h8, 32'h0, "R4 clkdiv reset");
      rd(4'hC, 32'h0, "R4 key disarmed");
      rd(4'h0, 32'h5000_0000, "R7 info word");

      // R3 locked write ignored
      wr(4'h4, 32'h1234_5678);
      rd(4'h4, 32'h0000_00F0, "R3 locked devcfg");
      wr(4'h8, 32'h0000_1111);
      rd(4'h8, 32'h0, "R3 locked clkdiv");

      // R1 / R2 arming, reads keep armed
      wr(4'hC, 32'h0000_00AA);
      rd(4'hC, 32'h1, "R1 armed");
      rd(4'hC, 32'h1, "R2 read keeps armed");
      wr(4'h4, 32'h5A5A_0F0F);
      rd(4'h4, 32'h5A5A_0F0F, "R5 devcfg readback");
      rd(4'hC, 32'h0, "R2 write disarms");
      @(negedge clk);
      check("R5 devcfg_o port", devcfg_o, 32'h5A5A_0F0F);
      @(posedge clk); #1;

      // R3 second write needs fresh key
      wr(4'h4, 32'h0000_0001);
      rd(4'h4, 32'h5A5A_0F0F, "R3 no fresh key");

      // R6 clock divider truncation
      wr(4'hC, 32'h0000_00AA);
      wr(4'h8, 32'hFFFF_ABCD);
      rd(4'h8, 32'h0000_ABCD, "R6 clkdiv width");
      @(negedge clk);
      check("R6 clkdiv_o port", clkdiv_o, 32'h0000_ABCD);
      @(posedge clk); #1;

      // R2 wrong key value
      wr(4'hC, 32'h0000_0055);
      rd(4'hC, 32'h0, "R2 wrong key");
      wr(4'hC, 32'h0000_01AA);
      rd(4'hC, 32'h0, "R2 key upper bits");

      // R1 key twice stays armed
      wr(4'hC, 32'h0000_00AA);
      wr(4'hC, 32'h0000_00AA);
      rd(4'hC, 32'h1, "R1 rekey armed");

      // R7 info write ignored, consumes key
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, 32'h5000_0000, "R7 info read-only");
      rd(4'hC, 32'h0, "R2 info write disarms");

      // R9 misaligned access
      wr(4'hC, 32'h0000_00AA);
      wr(4'h5, 32'h0);
      rd(4'h4, 32'h5A5A_0F0F, "R9 misaligned write");
      rd(4'hC, 32'h0, "R9 misaligned disarms");
      rd(4'h6, 32'h0, "R9 misaligned read");

      // R8 soft reset sequence
      wr(4'hC, 32'h0000_00AA);
      wr(4'h4, 32'h8000_00F0);
      pulse_chk(1'b0, "R8 set no pulse");
      wr(4'h4, 32'h0000_00F0);
      pulse_chk(1'b0, "R8 locked clear no pulse");
      rd(4'h4, 32'h8000_00F0, "R8 bit still set");
      wr(4'hC, 32'h0000_00AA);
      wr(4'h4, 32'h0000_00F0);
      pulse_chk(1'b1, "R8 clear pulses");
      wr(4'hC, 32'h0000_00AA);
      wr(4'h4, 32'h0000_00F0);
      pulse_chk(1'b0, "R8 zero rewrite no pulse");

      @(posedge clk); #1;
      done = 1'b1;
      summary();
      $finish;
   end

endmodule